// File: doc/BRIEF.md
# Paged Management Window to Wide Bus Bridge

This block sits behind a management register decoder that delivers 16-bit register accesses, each addressed by a 5-bit register number. It turns those narrow accesses into 32-bit reads and writes on a wide internal bus with 32-bit addresses. A page register decides which bank of management registers is visible. On the bridge page, a small window appears. It holds a mode register, a write address, a write data holding register, a read address and a latched read result. Each 32-bit value is split into an upper and a lower 16-bit half.

Software sets the address halves and then writes the data. The upper data half is written first. Writing the lower half commits one 32-bit internal write. Writing the lower half of the read address launches one internal read, whose result is latched for two halfword reads. With auto-increment enabled, software loads a start address once and streams data pairs, which suits bulk loading of firmware images. The internal side is a request/acknowledge port: a request is held until a one-cycle acknowledge arrives. While an internal access is pending, the management side is stalled through a ready signal.

Top module: `mgmt_window_bridge`

## Requirements
- R1: Register 0x1f is the page register. It resets to 0, can be written and read back on every page, and the bridge window is visible only when it holds 4.
- R2: When the page is not 4, management writes to registers 0x10 to 0x18 have no effect and issue no internal access, and reads of those registers return 0.
- R3: Register 0x10 bit 15 selects auto-increment (1) or fixed address (0). The other bits of this register read as 0.
- R4: Registers 0x11 and 0x12 hold the upper and lower halves of the write address. Register 0x13 holds the upper data half. All three read back what was last written.
- R5: A write to register 0x14 issues exactly one internal write. The data is {0x13 value, written value} and the address is the current write address.
- R6: After each committed write, the write address advances by 4 in auto-increment mode. In fixed mode it is unchanged.
- R7: Registers 0x15 and 0x16 hold the upper and lower halves of the read address. A write to 0x16 launches one internal read at {0x15 value, written value}.
- R8: Registers 0x17 and 0x18 return the upper and lower halves of the last internal read result. That result only changes when a later internal read completes.
- R9: The internal request stays high, with address, data and direction unchanged, until the acknowledge arrives. Only one access is outstanding at a time.
- R10: Management ready is low while an internal access is pending. A read of the read-data registers therefore waits until the result is latched.
- R11: Every accepted management read produces a one-cycle read-valid pulse in the next cycle, carrying the register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mgmtReq | input | 1 | Management access request, held until accepted |
| mgmtWe | input | 1 | 1 = write, 0 = read |
| mgmtReg | input | 5 | Management register number |
| mgmtWdata | input | 16 | Management write data |
| mgmtReady | output | 1 | Request accepted on a clock edge where this is high |
| mgmtRvalid | output | 1 | Read data valid pulse |
| mgmtRdata | output | 16 | Read data |
| busReq | output | 1 | Internal access request |
| busWe | output | 1 | Internal access direction, 1 = write |
| busAddr | output | 32 | Internal byte address |
| busWdata | output | 32 | Internal write data |
| busAck | input | 1 | One-cycle acknowledge |
| busRdata | input | 32 | Internal read data, valid with acknowledge |

## Verification
The bench streams a 16-word burst in increment mode and reads the write address back afterwards. A bridge that skipped or doubled its increment would leave holes in the memory model or end at the wrong address. Fixed-mode rewrites to one location check that the address does not drift. A read-modify-write checks that the latched result stays stable while a write to the same address completes underneath it. A design that exposed live bus data would show the new word there. Writes made while the page is 0 must not reach the bus or the holding registers, and a read issued straight after a launch must wait for the acknowledge instead of returning a stale word.

// File: rtl/mwb_pkg.sv
package mwb_pkg;
  localparam int HALF_W = 16;
  localparam int REG_W  = 5;
  localparam int WORD_W = 2 * HALF_W;

  localparam logic [REG_W-1:0] REG_PAGE   = 5'h1f;
  localparam logic [REG_W-1:0] REG_MODE   = 5'h10;
  localparam logic [REG_W-1:0] REG_WA_HI  = 5'h11;
  localparam logic [REG_W-1:0] REG_WA_LO  = 5'h12;
  localparam logic [REG_W-1:0] REG_WD_HI  = 5'h13;
  localparam logic [REG_W-1:0] REG_WD_LO  = 5'h14;
  localparam logic [REG_W-1:0] REG_RA_HI  = 5'h15;
  localparam logic [REG_W-1:0] REG_RA_LO  = 5'h16;
  localparam logic [REG_W-1:0] REG_RD_HI  = 5'h17;
  localparam logic [REG_W-1:0] REG_RD_LO  = 5'h18;

  typedef enum logic [3:0] {
    SEL_ZERO, SEL_PAGE, SEL_MODE, SEL_WAH, SEL_WAL, SEL_WDH, SEL_WDL,
    SEL_RAH, SEL_RAL, SEL_RDH, SEL_RDL
  } rdSel_e;

  typedef struct packed {
    logic   pageWr;
    logic   modeWr;
    logic   wrAddrHiWr;
    logic   wrAddrLoWr;
    logic   wrDataHiWr;
    logic   commitWr;
    logic   rdAddrHiWr;
    logic   launchRd;
    logic   captureRd;
    logic   rdStrobe;
    rdSel_e rdSel;
  } strobes_t;
endpackage

// File: rtl/mwb_ctrl.sv
module mwb_ctrl
  import mwb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             mgmtReq,
  input  logic             mgmtWe,
  input  logic [REG_W-1:0] mgmtReg,
  input  logic             pageIsBridge,
  input  logic             busAck,
  output logic             mgmtReady,
  output logic             mgmtRvalid,
  output logic             busReq,
  output logic             busWe,
  output strobes_t         st
);
  logic busy;
  logic accept;
  logic wrHit;
  rdSel_e sel;

  assign mgmtReady = !busy;
  assign busReq    = busy;
  assign accept    = mgmtReq && !busy;
  assign wrHit     = accept && mgmtWe && pageIsBridge;

  always_comb begin
    sel = SEL_ZERO;
    if (mgmtReg == REG_PAGE) sel = SEL_PAGE;
    else if (pageIsBridge) begin
      case (mgmtReg)
        REG_MODE:  sel = SEL_MODE;
        REG_WA_HI: sel = SEL_WAH;
        REG_WA_LO: sel = SEL_WAL;
        REG_WD_HI: sel = SEL_WDH;
        REG_WD_LO: sel = SEL_WDL;
        REG_RA_HI: sel = SEL_RAH;
        REG_RA_LO: sel = SEL_RAL;
        REG_RD_HI: sel = SEL_RDH;
        REG_RD_LO: sel = SEL_RDL;
        default:   sel = SEL_ZERO;
      endcase
    end
  end

  always_comb begin
    st            = '0;
    st.pageWr     = accept && mgmtWe && (mgmtReg == REG_PAGE);
    st.modeWr     = wrHit && (mgmtReg == REG_MODE);
    st.wrAddrHiWr = wrHit && (mgmtReg == REG_WA_HI);
    st.wrAddrLoWr = wrHit && (mgmtReg == REG_WA_LO);
    st.wrDataHiWr = wrHit && (mgmtReg == REG_WD_HI);
    st.commitWr   = wrHit && (mgmtReg == REG_WD_LO);
    st.rdAddrHiWr = wrHit && (mgmtReg == REG_RA_HI);
    st.launchRd   = wrHit && (mgmtReg == REG_RA_LO);
    st.captureRd  = busy && busAck && !busWe;
    st.rdStrobe   = accept && !mgmtWe;
    st.rdSel      = sel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy       <= 1'b0;
      busWe      <= 1'b0;
      mgmtRvalid <= 1'b0;
    end else begin
      mgmtRvalid <= accept && !mgmtWe;
      if (busy && busAck) begin
        busy <= 1'b0;
      end else if (st.commitWr || st.launchRd) begin
        busy  <= 1'b1;
        busWe <= st.commitWr;
      end
    end
  end
endmodule

// File: rtl/mwb_datapath.sv
module mwb_datapath
  import mwb_pkg::*;
#(
  parameter int BRIDGE_PAGE = 4,
  parameter int ADDR_STEP   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          st,
  input  logic [HALF_W-1:0] wdata,
  input  logic [WORD_W-1:0] busRdata,
  output logic              pageIsBridge,
  output logic [WORD_W-1:0] busAddr,
  output logic [WORD_W-1:0] busWdata,
  output logic [HALF_W-1:0] rdData
);
  logic [HALF_W-1:0] page;
  logic              incrMode;
  logic [WORD_W-1:0] wrAddr;
  logic [HALF_W-1:0] wrDataHi;
  logic [HALF_W-1:0] wrDataLo;
  logic [WORD_W-1:0] rdAddr;
  logic [WORD_W-1:0] rdLatch;
  logic [HALF_W-1:0] muxOut;

  assign pageIsBridge = (page == HALF_W'(BRIDGE_PAGE));

  always_comb begin
    case (st.rdSel)
      SEL_PAGE: muxOut = page;
      SEL_MODE: muxOut = {incrMode, {(HALF_W-1){1'b0}}};
      SEL_WAH:  muxOut = wrAddr[WORD_W-1:HALF_W];
      SEL_WAL:  muxOut = wrAddr[HALF_W-1:0];
      SEL_WDH:  muxOut = wrDataHi;
      SEL_WDL:  muxOut = wrDataLo;
      SEL_RAH:  muxOut = rdAddr[WORD_W-1:HALF_W];
      SEL_RAL:  muxOut = rdAddr[HALF_W-1:0];
      SEL_RDH:  muxOut = rdLatch[WORD_W-1:HALF_W];
      SEL_RDL:  muxOut = rdLatch[HALF_W-1:0];
      default:  muxOut = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      page     <= '0;
      incrMode <= 1'b0;
      wrAddr   <= '0;
      wrDataHi <= '0;
      wrDataLo <= '0;
      rdAddr   <= '0;
      rdLatch  <= '0;
      busAddr  <= '0;
      busWdata <= '0;
      rdData   <= '0;
    end else begin
      if (st.pageWr)     page     <= wdata;
      if (st.modeWr)     incrMode <= wdata[HALF_W-1];
      if (st.wrDataHiWr) wrDataHi <= wdata;
      if (st.rdAddrHiWr) rdAddr[WORD_W-1:HALF_W] <= wdata;
      if (st.captureRd)  rdLatch  <= busRdata;
      if (st.rdStrobe)   rdData   <= muxOut;

      if (st.wrAddrHiWr) wrAddr[WORD_W-1:HALF_W] <= wdata;
      else if (st.wrAddrLoWr) wrAddr[HALF_W-1:0] <= wdata;
      else if (st.commitWr && incrMode) wrAddr <= wrAddr + WORD_W'(ADDR_STEP);

      if (st.commitWr) begin
        wrDataLo <= wdata;
        busAddr  <= wrAddr;
        busWdata <= {wrDataHi, wdata};
      end else if (st.launchRd) begin
        rdAddr[HALF_W-1:0] <= wdata;
        busAddr <= {rdAddr[WORD_W-1:HALF_W], wdata};
      end
    end
  end
endmodule

// File: rtl/mgmt_window_bridge.sv
module mgmt_window_bridge
  import mwb_pkg::*;
#(
  parameter int BRIDGE_PAGE = 4,
  parameter int ADDR_STEP   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mgmtReq,
  input  logic              mgmtWe,
  input  logic [REG_W-1:0]  mgmtReg,
  input  logic [HALF_W-1:0] mgmtWdata,
  output logic              mgmtReady,
  output logic              mgmtRvalid,
  output logic [HALF_W-1:0] mgmtRdata,
  output logic              busReq,
  output logic              busWe,
  output logic [WORD_W-1:0] busAddr,
  output logic [WORD_W-1:0] busWdata,
  input  logic              busAck,
  input  logic [WORD_W-1:0] busRdata
);
  strobes_t st;
  logic     pageIsBridge;

  mwb_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .mgmtReq(mgmtReq), .mgmtWe(mgmtWe),
    .mgmtReg(mgmtReg), .pageIsBridge(pageIsBridge), .busAck(busAck),
    .mgmtReady(mgmtReady), .mgmtRvalid(mgmtRvalid), .busReq(busReq),
    .busWe(busWe), .st(st)
  );

  mwb_datapath #(.BRIDGE_PAGE(BRIDGE_PAGE), .ADDR_STEP(ADDR_STEP)) dp_i (
    .clk(clk), .rstN(rstN), .st(st), .wdata(mgmtWdata),
    .busRdata(busRdata), .pageIsBridge(pageIsBridge),
    .busAddr(busAddr), .busWdata(busWdata), .rdData(mgmtRdata)
  );
endmodule

// File: rtl/mwb_checker.sv
module mwb_checker
  import mwb_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              mgmtReq,
  input logic              mgmtWe,
  input logic [REG_W-1:0]  mgmtReg,
  input logic [HALF_W-1:0] mgmtWdata,
  input logic              mgmtReady,
  input logic              mgmtRvalid,
  input logic [HALF_W-1:0] mgmtRdata,
  input logic              busReq,
  input logic              busWe,
  input logic [WORD_W-1:0] busAddr,
  input logic [WORD_W-1:0] busWdata,
  input logic              busAck,
  input logic [WORD_W-1:0] busRdata
);
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq);

  assert_bus_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> $stable(busAddr) && $stable(busWdata) && $stable(busWe));

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> !mgmtReady);

  assert_rvalid_R11: assert property (@(posedge clk) disable iff (!rstN)
    mgmtReq && mgmtReady && !mgmtWe |=> mgmtRvalid);

  assert_rvalid_cause_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mgmtRvalid) |-> $past(mgmtReq && mgmtReady && !mgmtWe));

  assert_launch_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) |-> $past(mgmtReq && mgmtReady && mgmtWe));

  assert_ready_after_ack_R10: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busAck |=> mgmtReady);
endmodule

bind mgmt_window_bridge mwb_checker chk_i (.*);

// File: tb/mgmt_window_bridge_tb_top.sv
module mgmt_window_bridge_tb_top;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mgmtReq = 1'b0;
  logic        mgmtWe = 1'b0;
  logic [4:0]  mgmtReg = '0;
  logic [15:0] mgmtWdata = '0;
  logic        mgmtReady, mgmtRvalid;
  logic [15:0] mgmtRdata;
  logic        busReq, busWe;
  logic [31:0] busAddr, busWdata;
  logic        busAck = 1'b0;
  logic [31:0] busRdata = '0;

  int checks = 0;
  int failures = 0;
  int wrCount = 0;
  int latCnt = 0;
  logic [31:0] mem [256];
  logic [15:0] expQ[$];
  string       tagQ[$];

  always #10 clk = ~clk;

  mgmt_window_bridge dut_i (.*);

  // memory model on the internal bus
  always @(posedge clk) begin
    if (busReq && !busAck) begin
      if (latCnt == LAT - 1) begin
        busAck   <= 1'b1;
        busRdata <= mem[busAddr[9:2]];
        if (busWe) begin
          mem[busAddr[9:2]] <= busWdata;
          wrCount <= wrCount + 1;
        end
        latCnt <= 0;
      end else latCnt <= latCnt + 1;
    end else busAck <= 1'b0;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && mgmtRvalid) begin
      if (expQ.size() == 0) check(1'b0, "R11 unexpected rvalid", {16'h0, mgmtRdata}, 32'h0);
      else begin
        automatic logic [15:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        check(mgmtRdata === e, t, {16'h0, mgmtRdata}, {16'h0, e});
      end
    end
  end

  task automatic access(input logic we, input logic [4:0] r, input logic [15:0] d);
    @(negedge clk);
    mgmtReq = 1'b1; mgmtWe = we; mgmtReg = r; mgmtWdata = d;
    while (!mgmtReady) @(negedge clk);
    @(negedge clk);
    mgmtReq = 1'b0;
  endtask

  task automatic wr(input logic [4:0] r, input logic [15:0] d);
    access(1'b1, r, d);
  endtask

  task automatic rd(input logic [4:0] r, input logic [15:0] e, input string tag);
    expQ.push_back(e);
    tagQ.push_back(tag);
    access(1'b0, r, 16'h0);
  endtask

  task automatic waitIdle();
    repeat (2) @(negedge clk);
    while (!mgmtReady) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] burstWord(input int i);
    return 32'hC0DE0000 + 32'(i) * 32'h00010003;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int base;
    logic [31:0] oldW, newW;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(mgmtReady === 1'b1, "R10 ready after reset", {31'h0, mgmtReady}, 32'h1);
    check(busReq === 1'b0, "R9 no request after reset", {31'h0, busReq}, 32'h0);
    rd(5'h1f, 16'h0000, "R1 page resets to 0");

    // page 0: window hidden
    wr(5'h13, 16'h7777);
    rd(5'h13, 16'h0000, "R2 data hi reads 0 off page");
    wr(5'h14, 16'h9999);
    waitIdle();
    check(wrCount == 0, "R2 no bus write off page", 32'(wrCount), 32'h0);
    wr(5'h1f, 16'h0004);
    rd(5'h1f, 16'h0004, "R1 page readback");
    rd(5'h13, 16'h0000, "R2 ignored write left data hi");

    // mode register
    wr(5'h10, 16'h7fff);
    rd(5'h10, 16'h0000, "R3 low mode bits read 0");

    // single write, fixed mode
    wr(5'h11, 16'h0000);
    wr(5'h12, 16'h0020);
    rd(5'h12, 16'h0020, "R4 write addr lo");
    rd(5'h11, 16'h0000, "R4 write addr hi");
    wr(5'h13, 16'h1234);
    rd(5'h13, 16'h1234, "R4 write data hi");
    wr(5'h14, 16'h5678);
    waitIdle();
    check(mem[8] === 32'h12345678, "R5 single write data", mem[8], 32'h12345678);
    check(wrCount == 1, "R5 exactly one write", 32'(wrCount), 32'h1);
    rd(5'h12, 16'h0020, "R6 fixed addr unchanged");
    wr(5'h13, 16'hdead);
    wr(5'h14, 16'hbeef);
    waitIdle();
    check(mem[8] === 32'hdeadbeef, "R6 fixed rewrite same word", mem[8], 32'hdeadbeef);

    // burst in increment mode
    wr(5'h10, 16'h8001);
    rd(5'h10, 16'h8000, "R3 increment bit reads back");
    wr(5'h11, 16'h0000);
    wr(5'h12, 16'h0100);
    for (int i = 0; i < 16; i++) begin
      wr(5'h13, burstWord(i)[31:16]);
      wr(5'h14, burstWord(i)[15:0]);
    end
    waitIdle();
    check(wrCount == 18, "R5 one write per pair", 32'(wrCount), 32'd18);
    base = 64;
    for (int i = 0; i < 16; i++)
      check(mem[base+i] === burstWord(i), "R6 burst word", mem[base+i], burstWord(i));
    rd(5'h12, 16'h0140, "R6 address advanced by 64");

    // single read
    wr(5'h10, 16'h0000);
    wr(5'h15, 16'h0000);
    wr(5'h16, 16'h0104);
    check(mgmtReady === 1'b0, "R10 stall while read pending", {31'h0, mgmtReady}, 32'h0);
    rd(5'h17, burstWord(1)[31:16], "R8 read data hi");
    rd(5'h18, burstWord(1)[15:0], "R8 read data lo");
    rd(5'h16, 16'h0104, "R7 read addr lo");

    // overwrite the same word: latch must not move
    wr(5'h11, 16'h0000);
    wr(5'h12, 16'h0104);
    wr(5'h13, 16'hfeed);
    wr(5'h14, 16'hface);
    waitIdle();
    rd(5'h17, burstWord(1)[31:16], "R8 latch held hi");
    rd(5'h18, burstWord(1)[15:0], "R8 latch held lo");

    // read-modify-write on 0x108
    oldW = burstWord(2);
    newW = (oldW & ~32'h0000ff00) | 32'h00003c00;
    wr(5'h16, 16'h0108);
    rd(5'h17, oldW[31:16], "R7 rmw read hi");
    rd(5'h18, oldW[15:0], "R7 rmw read lo");
    wr(5'h12, 16'h0108);
    wr(5'h13, newW[31:16]);
    wr(5'h14, newW[15:0]);
    waitIdle();
    check(mem[66] === newW, "R5 rmw result in memory", mem[66], newW);
    wr(5'h16, 16'h0108);
    rd(5'h18, newW[15:0], "R8 rmw readback lo");

    // off-page again: window reads zero
    wr(5'h1f, 16'h0000);
    rd(5'h17, 16'h0000, "R2 read data hidden off page");
    rd(5'h1f, 16'h0000, "R1 page 0 readback");

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R11 all reads answered", 32'(expQ.size()), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule